// File: doc/BRIEF.md
# PLL Coefficient Bank with Frequency Ceilings

This block holds the divider coefficients for two clock synthesizers: a pixel-clock synthesizer with three switchable coefficient sets and a system-clock synthesizer with a single set. Each set is a triple M, N, P. The synthesized frequency is the reference times (N+1), divided by (M+1)(P+1). The block also keeps the frequency ceilings. It refuses any setting that would push a synthesizer past its ceiling, so the host cannot switch the clock to an illegal value.

A host loads coefficients and ceilings through a single write port. Sets 0 and 1 hold the two fixed legacy display modes. They are loaded once at start-up and are not checked when written. Set 2 is reloaded on every mode change, and each write to it is checked. A select strobe chooses the active pixel set. The check is made in the cycle the request is sampled, and its result is registered. The request then takes effect on the following edge, or it is refused. A refusal leaves the previous state in place and raises a sticky error flag. A second flag reports when the active pixel set exceeds the current ceiling, which can happen after the colour depth or the reference changes. Every frequency is handled as an integer in kHz, and the compare uses no division.

Top module: `pll_coef_bank`

## Requirements
- R1: Reset gives active_sel=0, zero coefficients on all pixel and system outputs, err_flag=0 and over_flag=0. Every ceiling field resets to all ones, which decodes to 355 MHz for the pixel ceilings and 1020 MHz for the system ceiling.
- R2: ref_sel=0 selects a 14318 kHz reference and ref_sel=1 selects 27000 kHz. A write to set 2 is accepted exactly when ref*(N+1)/((M+1)(P+1)) is at most the pixel ceiling in kHz. Equality is accepted.
- R3: A pixel ceiling field decodes to (field+100) MHz. The effective pixel ceiling is the smaller of the PLL maximum and the ceiling for the current depth. depth 0, 1, 2 and 3 stand for 8, 16, 24 and 32 bits per pixel.
- R4: Write address map: 0, 1 and 2 are pixel sets, 3 is the system set, 4 is the PLL maximum, 5 to 8 are the depth ceilings for depth 0 to 3, and 9 is the system ceiling. The coefficient format is wr_data[14:10]=M, [9:3]=N and [2:0]=P. Ceilings use wr_data[7:0]. Other addresses have no effect.
- R5: A write to set 0 or set 1 is stored without any check and never sets err_flag.
- R6: A sel_valid pulse with sel_req 0 to 2 is checked against the effective pixel ceiling. active_sel and the pixel outputs do not change at the edge that samples the request; when it is legal they change at the next edge. An over-ceiling set or sel_req=3 is refused, and active_sel stays unchanged.
- R7: A refused write to set 2 leaves its contents unchanged. When set 2 is active, the pixel outputs keep their old value.
- R8: A write to the system set is accepted only if its frequency is at most 4*field MHz (field at address 9). Accepted values appear on sys_m, sys_n and sys_p two edges after the write.
- R9: Any refused write or select sets err_flag. err_flag stays set until an err_clr pulse. A refusal that lands in the same cycle as err_clr wins.
- R10: over_flag is 1 exactly when the active pixel set exceeds the current effective ceiling under the current reference. It is updated one edge after the pixel outputs or the ceilings change.
- R11: When a select and a write to set 2 are sampled in the same cycle, the select is judged on the contents of set 2 before the write. When both are accepted, the pixel outputs show the newly written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_sel | input | 1 | Reference choice: 0 is 14318 kHz, 1 is 27000 kHz |
| depth | input | 2 | Colour depth code, 0 to 3 for 8/16/24/32 bpp |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 15 | Host write data (coefficients or ceiling) |
| sel_valid | input | 1 | Pixel set select strobe |
| sel_req | input | 2 | Requested pixel set |
| err_clr | input | 1 | Clears the sticky error flag |
| active_sel | output | 2 | Active pixel set |
| pix_m | output | 5 | Active pixel set M |
| pix_n | output | 7 | Active pixel set N |
| pix_p | output | 3 | Active pixel set P |
| sys_m | output | 5 | System set M |
| sys_n | output | 7 | System set N |
| sys_p | output | 3 | System set P |
| err_flag | output | 1 | Sticky refusal flag |
| over_flag | output | 1 | Active pixel set is above its ceiling |

## Verification
A select strobe and a write to set 2 can both be sampled in one cycle. Their checks are then made against different contents of set 2. This is provoked twice by raising both strobes together. In the first case both the old and the new contents fit, and the outputs must show the new triple with err_flag low. In the second case the depth has just been lowered so that the old contents no longer fit. The write must land while the select is refused, and a later select of set 2 then shows that the write was stored.

// File: rtl/pllb_pkg.sv
package pllb_pkg;
  // reference choices in kHz
  localparam int unsigned REF0_KHZ    = 14318;
  localparam int unsigned REF1_KHZ    = 27000;
  // ceiling decode constants
  localparam int unsigned PIX_OFS_MHZ = 100;
  localparam int unsigned SYS_SCALE   = 4;
  // coefficient storage: three pixel sets then the system set
  localparam int unsigned NUM_PIX     = 3;
  localparam int unsigned NUM_SETS    = NUM_PIX + 1;
  localparam int unsigned SYS_IDX     = NUM_PIX;
  localparam int unsigned SET_REPROG  = 2;
  // ceiling storage: pll max, four depths, system
  localparam int unsigned NUM_DEPTHS  = 4;
  localparam int unsigned NUM_LIMS    = NUM_DEPTHS + 2;
  localparam int unsigned LIM_BASE    = NUM_SETS;
endpackage

// File: rtl/pllb_freq_chk.sv
module pllb_freq_chk #(
  parameter int M_W   = 5,
  parameter int N_W   = 7,
  parameter int P_W   = 3,
  parameter int REF_W = 15,
  parameter int MHZ_W = 11
) (
  input  logic [REF_W-1:0] ref_khz,
  input  logic [M_W-1:0]   m,
  input  logic [N_W-1:0]   n,
  input  logic [P_W-1:0]   p,
  input  logic [MHZ_W-1:0] lim_mhz,
  output logic             ok
);
  localparam int KHZ_W = 10;
  localparam int W     = REF_W + N_W + MHZ_W + KHZ_W + M_W + P_W + 4;

  logic [W-1:0] n1, m1, p1, lhs, rhs;

  // ref*(N+1) <= lim*1000*(M+1)*(P+1), no divider needed
  always_comb begin
    n1  = W'(n) + W'(1);
    m1  = W'(m) + W'(1);
    p1  = W'(p) + W'(1);
    lhs = W'(ref_khz) * n1;
    rhs = W'(lim_mhz) * W'(1000) * m1 * p1;
    ok  = (lhs <= rhs);
  end
endmodule

// File: rtl/pllb_coef_bank.sv
module pllb_coef_bank
  import pllb_pkg::*;
#(
  parameter int CW = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(NUM_SETS)-1:0] waddr,
  input  logic [CW-1:0]            wdata,
  output logic [NUM_SETS*CW-1:0]   sets_flat
);
  logic [CW-1:0] set_q [NUM_SETS];

  // kept in flops: three sets are read in parallel every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NUM_SETS); i++) set_q[i] <= '0;
    end else if (we) begin
      set_q[waddr] <= wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < int'(NUM_SETS); i++) sets_flat[i*CW +: CW] = set_q[i];
  end
endmodule

// File: rtl/pllb_limits.sv
module pllb_limits
  import pllb_pkg::*;
#(
  parameter int LIM_W  = 8,
  parameter int ADDR_W = 4,
  parameter int MHZ_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LIM_W-1:0]  wdata,
  input  logic [1:0]        depth,
  output logic [MHZ_W-1:0]  pix_lim_mhz,
  output logic [MHZ_W-1:0]  sys_lim_mhz
);
  logic [LIM_W-1:0] lim_q [NUM_LIMS];
  logic [2:0]       dep_idx;
  logic [MHZ_W-1:0] pll_mhz, dep_mhz;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NUM_LIMS); i++) lim_q[i] <= '1;
    end else if (we) begin
      for (int i = 0; i < int'(NUM_LIMS); i++)
        if (waddr == ADDR_W'(int'(LIM_BASE) + i)) lim_q[i] <= wdata;
    end
  end

  // offset decode for pixel fields, scaled decode for the system field
  always_comb begin
    dep_idx     = 3'd1 + {1'b0, depth};
    pll_mhz     = MHZ_W'(lim_q[0]) + MHZ_W'(PIX_OFS_MHZ);
    dep_mhz     = MHZ_W'(lim_q[dep_idx]) + MHZ_W'(PIX_OFS_MHZ);
    pix_lim_mhz = (pll_mhz < dep_mhz) ? pll_mhz : dep_mhz;
    sys_lim_mhz = MHZ_W'(lim_q[NUM_LIMS-1]) * MHZ_W'(SYS_SCALE);
  end
endmodule

// File: rtl/pll_coef_bank.sv
module pll_coef_bank
  import pllb_pkg::*;
#(
  parameter int M_W    = 5,
  parameter int N_W    = 7,
  parameter int P_W    = 3,
  parameter int LIM_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ref_sel,
  input  logic [1:0]             depth,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [M_W+N_W+P_W-1:0] wr_data,
  input  logic                   sel_valid,
  input  logic [1:0]             sel_req,
  input  logic                   err_clr,
  output logic [1:0]             active_sel,
  output logic [M_W-1:0]         pix_m,
  output logic [N_W-1:0]         pix_n,
  output logic [P_W-1:0]         pix_p,
  output logic [M_W-1:0]         sys_m,
  output logic [N_W-1:0]         sys_n,
  output logic [P_W-1:0]         sys_p,
  output logic                   err_flag,
  output logic                   over_flag
);
  localparam int CW    = M_W + N_W + P_W;
  localparam int REF_W = 15;
  localparam int MHZ_W = LIM_W + 3;
  localparam int IDX_W = $clog2(NUM_SETS);

  // ---------------- storage ----------------
  logic [NUM_SETS*CW-1:0] sets_flat;
  logic [CW-1:0]          set_w [NUM_SETS];
  logic [MHZ_W-1:0]       pix_lim, sys_lim;

  // stage-1 (checked request) registers
  logic              wr_pend_q, wr_ok_q, sel_pend_q, sel_ok_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [CW-1:0]     wr_data_q;
  logic [1:0]        sel_req_q;

  // commit decisions
  logic wr_commit, wr_refuse, sel_commit, sel_refuse;

  pllb_coef_bank #(.CW(CW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_commit && (wr_addr_q < ADDR_W'(NUM_SETS))),
    .waddr     (wr_addr_q[IDX_W-1:0]),
    .wdata     (wr_data_q),
    .sets_flat (sets_flat)
  );

  pllb_limits #(.LIM_W(LIM_W), .ADDR_W(ADDR_W), .MHZ_W(MHZ_W)) u_lims (
    .clk         (clk),
    .rst         (rst),
    .we          (wr_commit),
    .waddr       (wr_addr_q),
    .wdata       (wr_data_q[LIM_W-1:0]),
    .depth       (depth),
    .pix_lim_mhz (pix_lim),
    .sys_lim_mhz (sys_lim)
  );

  for (genvar g = 0; g < int'(NUM_SETS); g++) begin : g_unpack
    assign set_w[g] = sets_flat[g*CW +: CW];
  end

  // ---------------- request checks ----------------
  logic [REF_W-1:0] ref_khz;
  logic [CW-1:0]    sel_cand;
  logic [MHZ_W-1:0] wr_lim;
  logic             sel_fit, wr_fit, wr_checked, sel_in_range;

  always_comb begin
    ref_khz      = ref_sel ? REF_W'(REF1_KHZ) : REF_W'(REF0_KHZ);
    sel_cand     = set_w[sel_req];
    sel_in_range = ({1'b0, sel_req} < 3'(NUM_PIX));
    wr_checked   = (wr_addr == ADDR_W'(SET_REPROG)) || (wr_addr == ADDR_W'(SYS_IDX));
    wr_lim       = (wr_addr == ADDR_W'(SYS_IDX)) ? sys_lim : pix_lim;
  end

  pllb_freq_chk #(.M_W(M_W), .N_W(N_W), .P_W(P_W), .REF_W(REF_W), .MHZ_W(MHZ_W)) u_chk_sel (
    .ref_khz (ref_khz),
    .m       (sel_cand[CW-1 -: M_W]),
    .n       (sel_cand[N_W+P_W-1 -: N_W]),
    .p       (sel_cand[P_W-1:0]),
    .lim_mhz (pix_lim),
    .ok      (sel_fit)
  );

  pllb_freq_chk #(.M_W(M_W), .N_W(N_W), .P_W(P_W), .REF_W(REF_W), .MHZ_W(MHZ_W)) u_chk_wr (
    .ref_khz (ref_khz),
    .m       (wr_data[CW-1 -: M_W]),
    .n       (wr_data[N_W+P_W-1 -: N_W]),
    .p       (wr_data[P_W-1:0]),
    .lim_mhz (wr_lim),
    .ok      (wr_fit)
  );

  // check result registered with the request (R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend_q  <= 1'b0;
      wr_ok_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      sel_pend_q <= 1'b0;
      sel_ok_q   <= 1'b0;
      sel_req_q  <= '0;
    end else begin
      wr_pend_q  <= wr_en;
      wr_ok_q    <= wr_fit || !wr_checked;
      wr_addr_q  <= wr_addr;
      wr_data_q  <= wr_data;
      sel_pend_q <= sel_valid;
      sel_ok_q   <= sel_fit && sel_in_range;
      sel_req_q  <= sel_req;
    end
  end

  // ---------------- commit ----------------
  logic [1:0]    act_q, nxt_sel;
  logic [CW-1:0] pix_q, nxt_pix;
  logic          err_q, over_q, act_fit;

  always_comb begin
    wr_commit  = wr_pend_q && wr_ok_q;
    wr_refuse  = wr_pend_q && !wr_ok_q;
    sel_commit = sel_pend_q && sel_ok_q;
    sel_refuse = sel_pend_q && !sel_ok_q;
    nxt_sel    = sel_commit ? sel_req_q : act_q;
    // a write landing in the newly active set is shown at once (R11)
    nxt_pix    = (wr_commit && (wr_addr_q == ADDR_W'(nxt_sel))) ? wr_data_q : set_w[nxt_sel];
  end

  pllb_freq_chk #(.M_W(M_W), .N_W(N_W), .P_W(P_W), .REF_W(REF_W), .MHZ_W(MHZ_W)) u_chk_act (
    .ref_khz (ref_khz),
    .m       (pix_q[CW-1 -: M_W]),
    .n       (pix_q[N_W+P_W-1 -: N_W]),
    .p       (pix_q[P_W-1:0]),
    .lim_mhz (pix_lim),
    .ok      (act_fit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      pix_q  <= '0;
      err_q  <= 1'b0;
      over_q <= 1'b0;
    end else begin
      act_q  <= nxt_sel;
      pix_q  <= nxt_pix;
      over_q <= !act_fit;
      if (wr_refuse || sel_refuse) err_q <= 1'b1;   // refusal beats clear
      else if (err_clr)            err_q <= 1'b0;
    end
  end

  assign active_sel = act_q;
  assign pix_m      = pix_q[CW-1 -: M_W];
  assign pix_n      = pix_q[N_W+P_W-1 -: N_W];
  assign pix_p      = pix_q[P_W-1:0];
  assign sys_m      = set_w[SYS_IDX][CW-1 -: M_W];
  assign sys_n      = set_w[SYS_IDX][N_W+P_W-1 -: N_W];
  assign sys_p      = set_w[SYS_IDX][P_W-1:0];
  assign err_flag   = err_q;
  assign over_flag  = over_q;
endmodule

// File: rtl/pllb_sva.sv
module pllb_sva #(
  parameter int M_W    = 5,
  parameter int N_W    = 7,
  parameter int P_W    = 3,
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ref_sel,
  input logic [1:0]             depth,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [M_W+N_W+P_W-1:0] wr_data,
  input logic                   sel_valid,
  input logic [1:0]             sel_req,
  input logic                   err_clr,
  input logic [1:0]             active_sel,
  input logic [M_W-1:0]         pix_m,
  input logic [N_W-1:0]         pix_n,
  input logic [P_W-1:0]         pix_p,
  input logic [M_W-1:0]         sys_m,
  input logic [N_W-1:0]         sys_n,
  input logic [P_W-1:0]         sys_p,
  input logic                   err_flag,
  input logic                   over_flag
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (active_sel == 2'd0 && !err_flag && !over_flag)) else $error("reset state"); // R1

  AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(sel_valid, 2)) |-> $stable(active_sel))
    else $error("active set moved without request"); // R6

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    active_sel != 2'd3) else $error("system slot active"); // R6

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(wr_en, 2) && !$past(sel_valid, 2))
    |-> $stable({pix_m, pix_n, pix_p})) else $error("pixel outputs moved"); // R7

  AST_SYS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(wr_en, 2)) |-> $stable({sys_m, sys_n, sys_p}))
    else $error("system outputs moved"); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag) else $error("error flag dropped"); // R9
endmodule

bind pll_coef_bank pllb_sva #(.M_W(M_W), .N_W(N_W), .P_W(P_W), .ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/pll_coef_bank_test.sv
module pll_coef_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, ref_sel, wr_en, sel_valid, err_clr;
  logic [1:0]  depth, sel_req;
  logic [3:0]  wr_addr;
  logic [14:0] wr_data;
  logic [1:0]  active_sel;
  logic [4:0]  pix_m, sys_m;
  logic [6:0]  pix_n, sys_n;
  logic [2:0]  pix_p, sys_p;
  logic        err_flag, over_flag;

  int n_chk = 0;
  int n_err = 0;

  // ceiling fields programmed by the bench
  int pll_fld;
  int dep_fld [4];

  // {ref_sel, depth, M, N, P, accept}
  localparam logic [18:0] VEC [9] = '{
    {1'b1, 2'd2, 5'd8, 7'd49,  3'd0, 1'b1},  // exactly 150 MHz at 150 ceiling
    {1'b1, 2'd2, 5'd8, 7'd50,  3'd0, 1'b0},  // 153 MHz
    {1'b0, 2'd0, 5'd0, 7'd15,  3'd0, 1'b1},  // 229.1 MHz at 250
    {1'b0, 2'd3, 5'd0, 7'd15,  3'd0, 1'b0},  // 229.1 MHz at 120
    {1'b1, 2'd0, 5'd0, 7'd8,   3'd0, 1'b1},  // 243 MHz at 250
    {1'b1, 2'd1, 5'd0, 7'd8,   3'd0, 1'b0},  // 243 MHz at 200
    {1'b1, 2'd1, 5'd1, 7'd15,  3'd1, 1'b1},  // 108 MHz
    {1'b1, 2'd3, 5'd0, 7'd127, 3'd7, 1'b0},  // 432 MHz
    {1'b0, 2'd3, 5'd2, 7'd24,  3'd0, 1'b1}   // 119.3 MHz at 120
  };

  pll_coef_bank uut (
    .clk(clk), .rst(rst), .ref_sel(ref_sel), .depth(depth),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_valid(sel_valid), .sel_req(sel_req), .err_clr(err_clr),
    .active_sel(active_sel), .pix_m(pix_m), .pix_n(pix_n), .pix_p(pix_p),
    .sys_m(sys_m), .sys_n(sys_n), .sys_p(sys_p),
    .err_flag(err_flag), .over_flag(over_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [14:0] cf(int m, int n, int p);
    return {5'(m), 7'(n), 3'(p)};
  endfunction

  function automatic real pix_ceiling(int dep);
    real a = real'(pll_fld + 100);
    real b = real'(dep_fld[dep] + 100);
    return (a < b) ? a : b;
  endfunction

  function automatic bit fits(bit rs, int m, int n, int p, real lim_mhz);
    real r = rs ? 27000.0 : 14318.0;
    return (r * real'(n + 1)) / real'((m + 1) * (p + 1)) <= lim_mhz * 1000.0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    wr_en = 1'b0; sel_valid = 1'b0; err_clr = 1'b0;
  endtask

  task automatic put_wr(int addr, logic [14:0] data);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
  endtask

  task automatic put_sel(int s);
    sel_valid = 1'b1; sel_req = 2'(s);
  endtask

  task automatic clear_err();
    err_clr = 1'b1; step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [18:0] v;
    int mm, mn, mp;
    rst = 1'b1; ref_sel = 1'b0; depth = 2'd0; wr_en = 1'b0; wr_addr = '0;
    wr_data = '0; sel_valid = 1'b0; sel_req = '0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 active_sel", active_sel, 0);
    chk("R1 pix_n", pix_n, 0);
    chk("R1 sys_n", sys_n, 0);
    chk("R1 err", err_flag, 0);
    chk("R1 over", over_flag, 0);

    // program ceilings (R4 map): pll 300, depths 250/200/150/120, system 300
    pll_fld = 200; dep_fld = '{150, 100, 50, 20};
    put_wr(4, 15'(pll_fld)); step();
    for (int d = 0; d < 4; d++) begin put_wr(5 + d, 15'(dep_fld[d])); step(); end
    put_wr(9, 15'd75); step();
    step();

    // R6 latency: select set 2
    put_sel(2); step();
    chk("R6 not yet", active_sel, 0);
    step();
    chk("R6 taken", active_sel, 2);

    // vector walk over set-2 writes (R2, R3, R7, R10, R9)
    mm = 0; mn = 0; mp = 0;
    for (int i = 0; i < 9; i++) begin
      v = VEC[i];
      ref_sel = v[18]; depth = v[17:16];
      put_wr(2, v[15:1]); step(); step();
      if (v[0]) begin mm = int'(v[15:11]); mn = int'(v[10:4]); mp = int'(v[3:1]); end
      chk($sformatf("R2 vec%0d pix_n", i), pix_n, mn);
      chk($sformatf("R7 vec%0d pix_m", i), pix_m, mm);
      chk($sformatf("R7 vec%0d pix_p", i), pix_p, mp);
      chk($sformatf("R9 vec%0d err", i), err_flag, v[0] ? 0 : 1);
      step();
      chk($sformatf("R10 vec%0d over", i), over_flag,
          fits(v[18], mm, mn, mp, pix_ceiling(int'(v[17:16]))) ? 0 : 1);
      clear_err();
      chk($sformatf("R9 vec%0d clr", i), err_flag, 0);
    end

    // R6 latency back to set 0
    put_sel(0); step();
    chk("R6 hold", active_sel, 2);
    step();
    chk("R6 set0", active_sel, 0);
    chk("R6 set0 n", pix_n, 0);

    // R5 unchecked write to set 1 (216 MHz at 120 ceiling), then refused select
    ref_sel = 1'b1; depth = 2'd3;
    put_wr(1, cf(0, 7, 0)); step(); step();
    chk("R5 no err", err_flag, 0);
    put_sel(1); step(); step();
    chk("R6 refused sel", active_sel, 0);
    chk("R6 refused err", err_flag, 1);
    clear_err();
    depth = 2'd0;
    put_sel(1); step(); step();
    chk("R5 stored sel", active_sel, 1);
    chk("R5 stored n", pix_n, 7);

    // R6 out-of-range select
    put_sel(3); step(); step();
    chk("R6 sel3 active", active_sel, 1);
    chk("R6 sel3 err", err_flag, 1);
    clear_err();

    // R8 system set: 297 MHz fits 300, 324 MHz does not
    put_wr(3, cf(0, 10, 0)); step(); step();
    chk("R8 sys accept", sys_n, 10);
    chk("R8 sys err0", err_flag, 0);
    put_wr(3, cf(0, 11, 0)); step(); step();
    chk("R8 sys refuse", sys_n, 10);
    chk("R8 sys err1", err_flag, 1);
    clear_err();

    // R3 pll maximum dominates the depth ceiling
    put_wr(4, 15'd0); step(); step();
    put_wr(2, cf(1, 15, 1)); step(); step();
    chk("R3 pll max refuse", err_flag, 1);
    chk("R10 over pll max", over_flag, 1);
    put_wr(4, 15'd200); step(); step(); step();
    chk("R10 over clear", over_flag, 0);
    clear_err();

    // R11 collision, both legal
    put_sel(2); put_wr(2, cf(0, 8, 0)); step(); step();
    chk("R11 both active", active_sel, 2);
    chk("R11 both n", pix_n, 8);
    chk("R11 both err", err_flag, 0);
    // R11 collision, old contents illegal, new legal
    put_sel(0); step(); step();
    depth = 2'd3;
    put_sel(2); put_wr(2, cf(1, 15, 1)); step(); step();
    chk("R11 split active", active_sel, 0);
    chk("R11 split err", err_flag, 1);
    clear_err();
    put_sel(2); step(); step();
    chk("R11 split stored n", pix_n, 15);
    chk("R11 split stored m", pix_m, 1);

    // R9 refusal beats a same-cycle clear
    put_sel(3); step();
    err_clr = 1'b1; step();
    chk("R9 set wins", err_flag, 1);
    clear_err();
    chk("R9 cleared", err_flag, 0);

    // R1 reset mid-run, ceilings back to 355 MHz
    rst = 1'b1; step(); step();
    rst = 1'b0;
    chk("R1 rerst active", active_sel, 0);
    chk("R1 rerst pix_m", pix_m, 0);
    chk("R1 rerst sys_n", sys_n, 0);
    chk("R1 rerst err", err_flag, 0);
    ref_sel = 1'b1; depth = 2'd3;
    put_wr(2, cf(0, 12, 0)); step(); step();
    put_sel(2); step(); step();
    chk("R1 reset ceiling n", pix_n, 12);
    chk("R1 reset ceiling err", err_flag, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule